// File: doc/BRIEF.md
# Write-Permission Control Register

This block holds an 8-bit control/status register that gates every write a serial-memory device can perform. Its image is `{3'b000, LK1, LK0, REN, WEN, 1'b0}`. `WEN` is the device-wide write-enable latch. `REN` is the register-write latch. `LK1:LK0` are two persistent lock bits. The bus front end is out of scope. A command decoder hands this block a single data byte on a valid/ready channel, a stop pulse that ends the transaction, a read request, and a pulse that reports an attempted write into a locked array region.

A data byte is judged as soon as it arrives and is answered with an acknowledge or a refusal. The action it requests takes effect only at the following stop. The two latches are volatile and change at once. A new lock value goes through a persistent write cycle that lasts `BUSY_CYCLES` clocks. No byte is taken while that cycle runs. A write-protect pin and the lock bits combine in a fixed priority table to give three permission outputs: array writes, volatile potentiometer writes and persistent potentiometer writes. The neighbouring array logic decodes the lock bits to find the protected address region.

Back-pressure: `wr_ready_o` is low while the persistent cycle runs and in any cycle where `stop_i` is high. A byte moves only on `wr_valid_i && wr_ready_o`. The read channel presents `rd_data_o` with `rd_valid_o` and holds both until `rd_ready_i` is seen.

Top module: `lockreg_ctl`

## Requirements
- R1: Bits 7:5 and bit 0 always read as 0. A data byte with any of those bits set is refused and has no effect.
- R2: Byte 02h, when REN is 0, is acknowledged and sets WEN at the stop. Byte 00h is always acknowledged and clears both WEN and REN at the stop. Neither starts a busy period.
- R3: A byte of the form 000xx110 is acknowledged only when WEN is 1. It then sets REN at the stop and leaves the lock bits unchanged. When WEN is 0 it is refused and has no effect.
- R4: With REN at 1 and the write-protect pin low, a byte 000ab010 is acknowledged. At the stop, `busy_o` rises for exactly BUSY_CYCLES cycles. When it falls, LK1:LK0 = ab and REN = 0.
- R5: The lock bits change only as a persistent cycle ends. `wr_ready_o` is low while `busy_o` is high.
- R6: Only one data byte is accepted per transaction. Any later byte before the stop is refused, and the whole transaction is discarded.
- R7: A pulse on `lock_viol_i` leaves REN at 0 on the next cycle.
- R8: While the write-protect pin is high, a lock-store byte is refused and changes nothing. Array writes and persistent potentiometer writes are not permitted.
- R9: Any lock value other than 00 forbids both kinds of potentiometer write. With lock 00 and the pin high, volatile potentiometer writes stay permitted.
- R10: The permissions are `arr = WEN & !busy & !wp`, `pot_vol = WEN & !busy & (lock==00)` and `pot_nv = pot_vol & !wp`.
- R11: A read request makes `rd_valid_o` rise on the next cycle with the register image. The data is held until `rd_ready_i`.
- R12: After reset, WEN = REN = 0, the lock bits equal LOCK_INIT, every permission is 0 and the block is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| wp_i | input | 1 | Write-protect pin, high protects |
| wr_valid_i | input | 1 | Data byte valid |
| wr_data_i | input | 8 | Data byte for the register |
| wr_ready_o | output | 1 | Byte can be taken |
| wr_resp_vld_o | output | 1 | Response for the byte taken last cycle |
| wr_resp_ack_o | output | 1 | 1 = acknowledged, 0 = refused |
| stop_i | input | 1 | End of transaction |
| rd_req_i | input | 1 | Read request pulse |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 8 | Register image |
| rd_ready_i | input | 1 | Read data consumed |
| lock_viol_i | input | 1 | Attempted write to a locked array region |
| busy_o | output | 1 | Persistent lock cycle running |
| lock_bits_o | output | 2 | Current lock bits for region decode |
| arr_wr_ok_o | output | 1 | Array write permitted |
| pot_vol_ok_o | output | 1 | Volatile potentiometer write permitted |
| pot_nv_ok_o | output | 1 | Persistent potentiometer write permitted |

## Verification
The hardest state to reach from the ports is a non-zero lock value with the write-protect pin then raised, and after that a return to lock 00. Getting there takes three acknowledged transactions in order: enable, register-enable, then a store with the pin low and a full busy wait. Only after that can the pin be raised. The directed part of the bench walks this chain on purpose and then stores 00 again to check the volatile permission under protection. The random part biases its byte pool toward the enable and register-enable codes, so the chain keeps recurring alongside double-byte and reserved-bit aborts.

// File: rtl/lockreg_pkg.sv
package lockreg_pkg;
  typedef enum logic [2:0] {
    ACT_REJECT   = 3'd0,
    ACT_SET_WEN  = 3'd1,
    ACT_CLR_ALL  = 3'd2,
    ACT_SET_REN  = 3'd3,
    ACT_STORE_LK = 3'd4
  } act_e;

  typedef struct packed {
    logic [2:0] rsv_hi;
    logic [1:0] lock;
    logic       ren;
    logic       wen;
    logic       rsv_lo;
  } csr_img_t;

  function automatic csr_img_t make_img(input logic [1:0] lock, input logic ren, input logic wen);
    csr_img_t img;
    img.rsv_hi = 3'b000;
    img.lock   = lock;
    img.ren    = ren;
    img.wen    = wen;
    img.rsv_lo = 1'b0;
    return img;
  endfunction
endpackage

// File: rtl/lockreg_decode.sv
module lockreg_decode
  import lockreg_pkg::*;
(
  input  logic [7:0] data_i,
  input  logic       wen_i,
  input  logic       ren_i,
  input  logic       wp_i,
  output act_e       act_o
);
  logic rsv_clean;
  logic lk_zero;

  assign rsv_clean = (data_i[7:5] == 3'b000) && !data_i[0];
  assign lk_zero   = (data_i[4:3] == 2'b00);

  always_comb begin
    act_o = ACT_REJECT;
    if (rsv_clean) begin
      case (data_i[2:1])
        2'b00: if (lk_zero) act_o = ACT_CLR_ALL;
        2'b01: begin
          if (ren_i) act_o = wp_i ? ACT_REJECT : ACT_STORE_LK;
          else if (lk_zero) act_o = ACT_SET_WEN;
        end
        2'b11: if (wen_i) act_o = ACT_SET_REN;
        default: act_o = ACT_REJECT;
      endcase
    end
  end
endmodule

// File: rtl/lockreg_nvtimer.sv
module lockreg_nvtimer #(
  parameter int unsigned BUSY_CYCLES = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_o) begin
      busy_o <= 1'b1;
      cnt_q  <= LOAD;
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/lockreg_perm.sv
module lockreg_perm (
  input  logic       wen_i,
  input  logic       busy_i,
  input  logic       wp_i,
  input  logic [1:0] lock_i,
  output logic       arr_ok_o,
  output logic       vol_ok_o,
  output logic       nv_ok_o
);
  logic live;
  logic unlocked;

  assign live     = wen_i && !busy_i;
  assign unlocked = (lock_i == 2'b00);
  assign arr_ok_o = live && !wp_i;
  assign vol_ok_o = live && unlocked;
  assign nv_ok_o  = live && unlocked && !wp_i;
endmodule

// File: rtl/lockreg_ctl.sv
module lockreg_ctl
  import lockreg_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 625000,
  parameter logic [1:0]  LOCK_INIT   = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wp_i,
  input  logic       wr_valid_i,
  input  logic [7:0] wr_data_i,
  output logic       wr_ready_o,
  output logic       wr_resp_vld_o,
  output logic       wr_resp_ack_o,
  input  logic       stop_i,
  input  logic       rd_req_i,
  output logic       rd_valid_o,
  output logic [7:0] rd_data_o,
  input  logic       rd_ready_i,
  input  logic       lock_viol_i,
  output logic       busy_o,
  output logic [1:0] lock_bits_o,
  output logic       arr_wr_ok_o,
  output logic       pot_vol_ok_o,
  output logic       pot_nv_ok_o
);
  logic       wen_q, ren_q;
  logic [1:0] lock_q, lock_nxt_q;
  logic       have_byte_q, aborted_q;
  act_e       pend_act_q;
  logic [1:0] pend_lk_q;
  act_e       act_now;
  logic       wr_fire, commit, store_go, nv_done;

  lockreg_decode u_dec (
    .data_i (wr_data_i),
    .wen_i  (wen_q),
    .ren_i  (ren_q),
    .wp_i   (wp_i),
    .act_o  (act_now)
  );

  assign wr_ready_o = !busy_o && !stop_i;
  assign wr_fire    = wr_valid_i && wr_ready_o;
  assign commit     = stop_i && have_byte_q;
  assign store_go   = commit && (pend_act_q == ACT_STORE_LK);

  lockreg_nvtimer #(.BUSY_CYCLES(BUSY_CYCLES)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (store_go),
    .busy_o  (busy_o),
    .done_o  (nv_done)
  );

  // transaction tracking: one byte per transaction, extra bytes abort
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_byte_q   <= 1'b0;
      aborted_q     <= 1'b0;
      pend_act_q    <= ACT_REJECT;
      pend_lk_q     <= 2'b00;
      wr_resp_vld_o <= 1'b0;
      wr_resp_ack_o <= 1'b0;
    end else begin
      wr_resp_vld_o <= wr_fire;
      wr_resp_ack_o <= 1'b0;
      if (stop_i) begin
        have_byte_q <= 1'b0;
        aborted_q   <= 1'b0;
      end else if (wr_fire) begin
        if (!have_byte_q && !aborted_q && (act_now != ACT_REJECT)) begin
          have_byte_q   <= 1'b1;
          pend_act_q    <= act_now;
          pend_lk_q     <= wr_data_i[4:3];
          wr_resp_ack_o <= 1'b1;
        end else begin
          have_byte_q <= 1'b0;
          aborted_q   <= 1'b1;
        end
      end
    end
  end

  // latches and lock bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q      <= 1'b0;
      ren_q      <= 1'b0;
      lock_q     <= LOCK_INIT;
      lock_nxt_q <= LOCK_INIT;
    end else begin
      if (commit) begin
        case (pend_act_q)
          ACT_SET_WEN:  wen_q <= 1'b1;
          ACT_CLR_ALL: begin
            wen_q <= 1'b0;
            ren_q <= 1'b0;
          end
          ACT_SET_REN:  ren_q <= 1'b1;
          ACT_STORE_LK: lock_nxt_q <= pend_lk_q;
          default: ;
        endcase
      end
      if (nv_done) begin
        lock_q <= lock_nxt_q;
        ren_q  <= 1'b0;
      end
      if (lock_viol_i) ren_q <= 1'b0;
    end
  end

  // read channel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= 8'h00;
    end else if (rd_req_i) begin
      rd_valid_o <= 1'b1;
      rd_data_o  <= make_img(lock_q, ren_q, wen_q);
    end else if (rd_ready_i) begin
      rd_valid_o <= 1'b0;
    end
  end

  assign lock_bits_o = lock_q;

  lockreg_perm u_perm (
    .wen_i    (wen_q),
    .busy_i   (busy_o),
    .wp_i     (wp_i),
    .lock_i   (lock_q),
    .arr_ok_o (arr_wr_ok_o),
    .vol_ok_o (pot_vol_ok_o),
    .nv_ok_o  (pot_nv_ok_o)
  );
endmodule

// File: rtl/lockreg_ctl_chk.sv
module lockreg_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_i,
  input logic       busy_o,
  input logic       rd_valid_o,
  input logic [7:0] rd_data_o,
  input logic [1:0] lock_bits_o,
  input logic       arr_wr_ok_o,
  input logic       pot_vol_ok_o,
  input logic       pot_nv_ok_o,
  input logic       lock_viol_i,
  input logic       wen_q,
  input logic       ren_q
);
  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> (rd_data_o[7:5] == 3'b000 && !rd_data_o[0])); // R1
  AST_REN_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    ren_q |-> wen_q); // R3
  AST_LOCK_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy_o) |-> $stable(lock_bits_o)); // R5
  AST_VIOL_CLEARS_REN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_viol_i |=> !ren_q); // R7
  AST_WP_BLOCKS_NV: assert property (@(posedge clk) disable iff (!rst_n)
    wp_i |-> (!pot_nv_ok_o && !arr_wr_ok_o)); // R8
  AST_LOCK_BLOCKS_POT: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_bits_o != 2'b00) |-> (!pot_vol_ok_o && !pot_nv_ok_o)); // R9
  AST_BUSY_NO_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!arr_wr_ok_o && !pot_vol_ok_o && !pot_nv_ok_o)); // R10
endmodule

bind lockreg_ctl lockreg_ctl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wp_i         (wp_i),
  .busy_o       (busy_o),
  .rd_valid_o   (rd_valid_o),
  .rd_data_o    (rd_data_o),
  .lock_bits_o  (lock_bits_o),
  .arr_wr_ok_o  (arr_wr_ok_o),
  .pot_vol_ok_o (pot_vol_ok_o),
  .pot_nv_ok_o  (pot_nv_ok_o),
  .lock_viol_i  (lock_viol_i),
  .wen_q        (wen_q),
  .ren_q        (ren_q)
);

// File: tb/lockreg_ctl_tb_top.sv
module lockreg_ctl_tb_top;
  localparam int unsigned BC = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp = 1'b0, wr_valid = 1'b0, stop = 1'b0, rd_req = 1'b0, rd_ready = 1'b0, viol = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic wr_ready, resp_vld, resp_ack, rd_valid, busy, arr_ok, vol_ok, nv_ok;
  logic [7:0] rd_data;
  logic [1:0] lock_bits;

  int checks = 0;
  int errors = 0;
  logic       m_wen = 1'b0, m_ren = 1'b0;
  logic [1:0] m_lk = 2'b00;

  always #4 clk = ~clk;

  lockreg_ctl #(.BUSY_CYCLES(BC), .LOCK_INIT(2'b00)) dut_i (
    .clk(clk), .rst_n(rst_n), .wp_i(wp),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .wr_resp_vld_o(resp_vld), .wr_resp_ack_o(resp_ack),
    .stop_i(stop), .rd_req_i(rd_req), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .rd_ready_i(rd_ready), .lock_viol_i(viol), .busy_o(busy),
    .lock_bits_o(lock_bits), .arr_wr_ok_o(arr_ok), .pot_vol_ok_o(vol_ok), .pot_nv_ok_o(nv_ok)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected action: 0 refuse, 1 set WEN, 2 clear both, 3 set REN, 4 store lock
  function automatic int exp_act(input logic [7:0] d, input logic wen, input logic ren, input logic p);
    if (d[7:5] != 3'b000 || d[0]) return 0;
    case (d[2:1])
      2'b00: return (d[4:3] == 2'b00) ? 2 : 0;
      2'b01: begin
        if (ren) return p ? 0 : 4;
        return (d[4:3] == 2'b00) ? 1 : 0;
      end
      2'b11: return wen ? 3 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic logic [2:0] exp_perm(input logic wen, input logic [1:0] lk, input logic p);
    logic v;
    v = wen && (lk == 2'b00);
    return {wen && !p, v, v && !p};
  endfunction

  task automatic check_state(input string req);
    logic [7:0] img;
    img = {3'b000, m_lk, m_ren, m_wen, 1'b0};
    @(negedge clk); rd_req = 1'b1;
    @(posedge clk); #1 rd_req = 1'b0;
    @(negedge clk);
    chk(rd_valid === 1'b1, {req, " R11 rd_valid"}, int'(rd_valid), 1);
    chk(rd_data === img, {req, " R11 image"}, int'(rd_data), int'(img));
    chk({arr_ok, vol_ok, nv_ok} === exp_perm(m_wen, m_lk, wp), {req, " R10 perms"},
        int'({arr_ok, vol_ok, nv_ok}), int'(exp_perm(m_wen, m_lk, wp)));
    rd_ready = 1'b1;
    @(posedge clk); #1 rd_ready = 1'b0;
    @(negedge clk);
    chk(rd_valid === 1'b0, {req, " R11 drop"}, int'(rd_valid), 0);
  endtask

  task automatic do_txn(input logic [7:0] d, input bit two, input string req);
    int a;
    int n;
    a = exp_act(d, m_wen, m_ren, wp);
    @(negedge clk); wr_valid = 1'b1; wr_data = d;
    @(posedge clk); #1 wr_valid = 1'b0;
    @(negedge clk);
    chk(resp_vld === 1'b1 && resp_ack === (a != 0), {req, " ack"}, int'(resp_ack), int'(a != 0));
    if (two) begin
      wr_valid = 1'b1; wr_data = d;
      @(posedge clk); #1 wr_valid = 1'b0;
      @(negedge clk);
      chk(resp_vld === 1'b1 && resp_ack === 1'b0, {req, " R6 second byte"}, int'(resp_ack), 0);
    end
    stop = 1'b1;
    @(posedge clk); #1 stop = 1'b0;
    @(negedge clk);
    if (!two && a == 4) begin
      n = 0;
      chk(wr_ready === 1'b0 && {arr_ok, vol_ok, nv_ok} === 3'b000, {req, " R5 R10 busy gate"},
          int'({wr_ready, arr_ok, vol_ok, nv_ok}), 0);
      while (busy === 1'b1) begin
        chk(lock_bits === m_lk, {req, " R5 lock held"}, int'(lock_bits), int'(m_lk));
        n++;
        @(negedge clk);
      end
      chk(n == BC, {req, " R4 busy length"}, n, BC);
      m_lk = d[4:3];
      m_ren = 1'b0;
    end else begin
      chk(busy === 1'b0, {req, " R2 no busy"}, int'(busy), 0);
      if (!two) begin
        case (a)
          1: m_wen = 1'b1;
          2: begin m_wen = 1'b0; m_ren = 1'b0; end
          3: m_ren = 1'b1;
          default: ;
        endcase
      end
    end
    check_state(req);
  endtask

  task automatic set_wp(input logic v);
    @(negedge clk); wp = v;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && {arr_ok, vol_ok, nv_ok} === 3'b000 && lock_bits === 2'b00,
        "R12 reset", int'({busy, arr_ok, vol_ok, nv_ok, lock_bits}), 0);
    check_state("R12");

    do_txn(8'h06, 1'b0, "R3 no WEN");
    do_txn(8'h02, 1'b0, "R2 set WEN");
    do_txn(8'h82, 1'b0, "R1 reserved hi");
    do_txn(8'h03, 1'b0, "R1 reserved lo");
    do_txn(8'h06, 1'b0, "R3 set REN");
    do_txn(8'h1E, 1'b0, "R3 keep REN");
    set_wp(1'b1);
    do_txn(8'h12, 1'b0, "R8 store under wp");
    set_wp(1'b0);
    do_txn(8'h12, 1'b0, "R4 store 10");
    set_wp(1'b1);
    check_state("R9 locked wp");
    set_wp(1'b0);
    check_state("R9 locked");
    do_txn(8'h06, 1'b0, "R3 again");
    do_txn(8'h02, 1'b0, "R4 store 00");
    set_wp(1'b1);
    check_state("R9 vol under wp");
    set_wp(1'b0);
    do_txn(8'h00, 1'b1, "R6 double clear");
    do_txn(8'h06, 1'b0, "R7 prep");
    @(negedge clk); viol = 1'b1;
    @(posedge clk); #1 viol = 1'b0;
    m_ren = 1'b0;
    check_state("R7 violation");

    for (int i = 0; i < 250; i++) begin
      logic [7:0] d;
      int sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1: d = 8'h02;
        2, 3: d = {3'b000, 2'($urandom), 3'b110};
        4, 5: d = {3'b000, 2'($urandom), 3'b010};
        6:    d = 8'h00;
        7:    d = 8'($urandom);
        default: d = {3'b000, 2'($urandom), 2'($urandom), 1'b0};
      endcase
      set_wp(($urandom_range(0, 3) == 0));
      if ($urandom_range(0, 15) == 0) begin
        @(negedge clk); viol = 1'b1;
        @(posedge clk); #1 viol = 1'b0;
        m_ren = 1'b0;
      end
      do_txn(d, ($urandom_range(0, 7) == 0), "R1 R2 R3 R4 R6 R8 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule